// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps time of day and the calendar as packed BCD: seconds, minutes, hours, a day-of-week index, date, month and a two-digit year. A prescaler counts enable pulses from a 32.768 kHz oscillator domain. Each time it wraps, it issues a one-second tick. The whole design runs on one system clock. On each tick the fields advance through a BCD carry chain. This chain knows the length of every month and supplies February 29 in leap years.

A host controls the counter through three requests. The hold request stops all counting and keeps the prescaler at zero while a write is in preparation. The load request writes minutes, hours, day of week, date, month and year in parallel. It forces seconds to 00 and restarts the prescaler from zero. The snapshot request copies every field into a set of output registers. Those registers keep their contents until the next snapshot, so the host reads one coherent set of values.

Top module: `bcd_calendar_clock`

## Requirements
- R1: Every output field is one byte of packed BCD, 4 bits per decimal digit (tens in bits 7:4, units in bits 3:0). Bits that a field's range never uses read as 0: sec bit 7, hour bits 7:6, day-of-week bits 7:3, date bits 7:6, month bits 7:5.
- R2: After reset the time is 00:00:00 with day of week 1, date 01, month 01 and year 00, and the snapshot outputs show these same values.
- R3: The prescaler issues one tick for every 2^PRESC_W registered oscillator-enable pulses. Seconds advance at the clock edge that registers the 2^PRESC_W-th enable since the prescaler was last cleared.
- R4: Seconds count 00 to 59, minutes 00 to 59 and hours 00 to 23. Each field wraps to 00 and carries into the next field within the same tick.
- R5: The day of week counts 1 to 7 and wraps from 7 to 1 on every day carry, independently of the date.
- R6: The date counts from 01 to the last day of the month (31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for 04, 06, 09 and 11; 28 for 02 in a common year). It then returns to 01 and advances the month.
- R7: February ends on day 29 when the BCD year is divisible by 4, year 00 included, and on day 28 otherwise.
- R8: A carry out of December 31 gives January 1 and advances the year; year 99 wraps to 00.
- R9: While hold is high and load is low, no field changes, the prescaler is held at zero, and oscillator enables have no effect.
- R10: A load cycle writes the minute, hour, day-of-week, date, month and year inputs, forces seconds to 00 and clears the prescaler. A load takes effect even when hold is high in the same cycle.
- R11: The snapshot outputs take the field values present before the edge at which snap is sampled high. They do not change at any other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en_i | input | 1 | One-cycle enable per oscillator period |
| hold_i | input | 1 | Halt counting and hold prescaler cleared |
| load_i | input | 1 | Parallel load strobe |
| ld_min_i | input | 8 | Minutes to load (BCD) |
| ld_hour_i | input | 8 | Hours to load (BCD) |
| ld_dow_i | input | 8 | Day of week to load, 1 to 7 |
| ld_date_i | input | 8 | Date to load (BCD) |
| ld_month_i | input | 8 | Month to load (BCD) |
| ld_year_i | input | 8 | Year to load (BCD) |
| snap_i | input | 1 | Snapshot request |
| sec_o | output | 8 | Snapshot seconds |
| min_o | output | 8 | Snapshot minutes |
| hour_o | output | 8 | Snapshot hours |
| dow_o | output | 8 | Snapshot day of week |
| date_o | output | 8 | Snapshot date |
| month_o | output | 8 | Snapshot month |
| year_o | output | 8 | Snapshot year |

## Verification
The hardest states to reach from the ports are month-end and year-end rollovers. In free-running time they lie weeks or years of ticks away. The bench shrinks the prescaler to four enables per tick and loads each candidate day at 23:59. The load forces seconds to zero, so sixty ticks cross midnight and land on the day boundary. This is repeated for every month across common, leap and wrapping years, and for every February of the century. The alignment of the prescaler after a hold or a load is checked by counting enables one short of a tick and then one more.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } cal_t;

    localparam logic [7:0] SEC_LAST   = 8'h59;
    localparam logic [7:0] MIN_LAST   = 8'h59;
    localparam logic [7:0] HOUR_LAST  = 8'h23;
    localparam logic [7:0] DOW_FIRST  = 8'h01;
    localparam logic [7:0] DOW_LAST   = 8'h07;
    localparam logic [7:0] DATE_FIRST = 8'h01;
    localparam logic [7:0] MON_FIRST  = 8'h01;
    localparam logic [7:0] MON_LAST   = 8'h12;
    localparam logic [7:0] YEAR_LAST  = 8'h99;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   dow: DOW_FIRST, date: DATE_FIRST,
                                   month: MON_FIRST, year: 8'h00};

    // Add one to a two-digit packed BCD value (caller handles wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A BCD year is a multiple of four when an even tens digit pairs with
    // units 0/4/8, or an odd tens digit pairs with units 2/6.
    function automatic logic is_leap(input logic [7:0] y);
        logic [3:0] u;
        u = y[3:0];
        if (y[4])
            return (u == 4'd2) || (u == 4'd6);
        else
            return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m,
                                              input logic       leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
    parameter int PRESC_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam logic [PRESC_W-1:0] CNT_TOP = {PRESC_W{1'b1}};

    logic [PRESC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (clear_i) begin
            cnt_d = '0;
        end else if (osc_en_i) begin
            cnt_d  = cnt_q + 1'b1;
            tick_o = (cnt_q == CNT_TOP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    presc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    // R3
    presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/bcd_cal_step.sv
module bcd_cal_step
    import bcd_cal_pkg::*;
(
    input  cal_t cur_i,
    output cal_t nxt_o
);
    logic       leap;
    logic [7:0] last_day;
    logic       wrap_sec, wrap_min, wrap_hour, wrap_date, wrap_mon;

    always_comb begin
        leap      = is_leap(cur_i.year);
        last_day  = month_last(cur_i.month, leap);
        wrap_sec  = (cur_i.sec   == SEC_LAST);
        wrap_min  = (cur_i.min   == MIN_LAST);
        wrap_hour = (cur_i.hour  == HOUR_LAST);
        wrap_date = (cur_i.date  == last_day);
        wrap_mon  = (cur_i.month == MON_LAST);

        nxt_o     = cur_i;
        nxt_o.sec = wrap_sec ? 8'h00 : bcd_inc(cur_i.sec);
        if (wrap_sec) begin
            nxt_o.min = wrap_min ? 8'h00 : bcd_inc(cur_i.min);
            if (wrap_min) begin
                nxt_o.hour = wrap_hour ? 8'h00 : bcd_inc(cur_i.hour);
                if (wrap_hour) begin
                    nxt_o.dow  = (cur_i.dow == DOW_LAST) ? DOW_FIRST
                                                         : bcd_inc(cur_i.dow);
                    nxt_o.date = wrap_date ? DATE_FIRST : bcd_inc(cur_i.date);
                    if (wrap_date) begin
                        nxt_o.month = wrap_mon ? MON_FIRST : bcd_inc(cur_i.month);
                        if (wrap_mon)
                            nxt_o.year = (cur_i.year == YEAR_LAST) ? 8'h00
                                                                   : bcd_inc(cur_i.year);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
    import bcd_cal_pkg::*;
#(
    parameter int PRESC_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en_i,
    input  logic       hold_i,
    input  logic       load_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hour_i,
    input  logic [7:0] ld_dow_i,
    input  logic [7:0] ld_date_i,
    input  logic [7:0] ld_month_i,
    input  logic [7:0] ld_year_i,
    input  logic       snap_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    typedef struct packed {
        cal_t cal;
        cal_t snap;
    } state_t;

    state_t st_d, st_q;
    logic   tick;
    logic   presc_clr;
    cal_t   cal_next;

    assign presc_clr = hold_i | load_i;

    bcd_cal_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_en_i (osc_en_i),
        .clear_i  (presc_clr),
        .tick_o   (tick)
    );

    bcd_cal_step u_step (
        .cur_i (st_q.cal),
        .nxt_o (cal_next)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cal.sec   = 8'h00;
            st_d.cal.min   = ld_min_i;
            st_d.cal.hour  = ld_hour_i;
            st_d.cal.dow   = ld_dow_i;
            st_d.cal.date  = ld_date_i;
            st_d.cal.month = ld_month_i;
            st_d.cal.year  = ld_year_i;
        end else if (tick) begin
            st_d.cal = cal_next;
        end
        if (snap_i)
            st_d.snap = st_q.cal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cal: CAL_RESET, snap: CAL_RESET};
        else        st_q <= st_d;
    end

    assign sec_o   = st_q.snap.sec;
    assign min_o   = st_q.snap.min;
    assign hour_o  = st_q.snap.hour;
    assign dow_o   = st_q.snap.dow;
    assign date_o  = st_q.snap.date;
    assign month_o = st_q.snap.month;
    assign year_o  = st_q.snap.year;

    // R10
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cal.sec == 8'h00) && (st_q.cal.min == $past(ld_min_i))
                && (st_q.cal.hour == $past(ld_hour_i))
                && (st_q.cal.year == $past(ld_year_i)));

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !load_i) |=> $stable(st_q.cal));

    // R4
    time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cal.sec <= SEC_LAST) && (st_q.cal.sec[3:0] <= 4'd9)
        && (st_q.cal.min <= MIN_LAST) && (st_q.cal.hour <= HOUR_LAST));

    // R4
    min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && st_q.cal.sec != SEC_LAST) |=> $stable(st_q.cal.min));

    // R5
    dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cal.dow >= DOW_FIRST) && (st_q.cal.dow <= DOW_LAST));

    // R6
    month_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cal.month >= MON_FIRST) && (st_q.cal.month <= MON_LAST)
        && (st_q.cal.date != 8'h00));

    // R11
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(st_q.snap));

endmodule

// File: tb/bcd_calendar_clock_tb_top.sv
module bcd_calendar_clock_tb_top;
    localparam int PW    = 2;
    localparam int ENPER = 1 << PW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0, hold = 1'b0, load = 1'b0, snap = 1'b0;
    logic [7:0] l_min = '0, l_hour = '0, l_dow = 8'h01, l_date = 8'h01;
    logic [7:0] l_mon = 8'h01, l_year = '0;
    logic [7:0] sec, min, hour, dow, date, month, year;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bcd_calendar_clock #(.PRESC_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_en_i(osc_en), .hold_i(hold),
        .load_i(load), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_dow_i(l_dow),
        .ld_date_i(l_date), .ld_month_i(l_mon), .ld_year_i(l_year),
        .snap_i(snap), .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow),
        .date_o(date), .month_o(month), .year_o(year)
    );

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int days_in(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic expect_cal(string tag, int s, int mi, int h, int dw,
                              int dt, int mo, int y);
        logic [55:0] got, exp;
        got = {sec, min, hour, dow, date, month, year};
        exp = {to_bcd(s), to_bcd(mi), to_bcd(h), to_bcd(dw), to_bcd(dt),
               to_bcd(mo), to_bcd(y)};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run_en(int n);
        osc_en = 1'b1;
        repeat (n) @(negedge clk);
        osc_en = 1'b0;
    endtask

    task automatic take_snap();
        snap = 1'b1;
        @(negedge clk);
        snap = 1'b0;
    endtask

    task automatic do_load(int mi, int h, int dw, int dt, int mo, int y,
                           bit with_hold);
        l_min = to_bcd(mi); l_hour = to_bcd(h); l_dow = to_bcd(dw);
        l_date = to_bcd(dt); l_mon = to_bcd(mo); l_year = to_bcd(y);
        hold = with_hold;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        hold = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset values visible on snapshot outputs before any snapshot
        expect_cal("R2 reset outputs", 0, 0, 0, 1, 1, 1, 0);
        take_snap();
        expect_cal("R2 reset snapshot", 0, 0, 0, 1, 1, 1, 0);
        // R1 unused high bits of dow and month read zero
        checks++;
        if (dow[7:3] !== 5'd0 || month[7:5] !== 3'd0 || sec[7] !== 1'b0) begin
            errors++;
            $display("FAIL R1 unused bits: got %h/%h expected 00/01", dow, month);
        end

        // R3 one enable short of a period gives no tick, the next one does
        run_en(ENPER - 1);
        take_snap();
        expect_cal("R3 short of period", 0, 0, 0, 1, 1, 1, 0);
        run_en(1);
        take_snap();
        expect_cal("R3 full period", 1, 0, 0, 1, 1, 1, 0);

        // R4 sweep through the first hour rollover, one check per tick
        for (int k = 2; k <= 3700; k++) begin
            run_en(ENPER);
            take_snap();
            expect_cal("R4 time sweep", k % 60, (k / 60) % 60, k / 3600, 1, 1, 1, 0);
        end
        t = 3700;

        // R11 ticks without a snapshot leave outputs unchanged
        run_en(2 * ENPER);
        @(negedge clk);
        expect_cal("R11 no snap stable", t % 60, (t / 60) % 60, t / 3600, 1, 1, 1, 0);
        take_snap();
        t = t + 2;
        expect_cal("R11 snap updates", t % 60, (t / 60) % 60, t / 3600, 1, 1, 1, 0);

        // R9 hold freezes time and clears a partly filled prescaler
        run_en(2);
        hold = 1'b1;
        run_en(3 * ENPER);
        take_snap();
        hold = 1'b0;
        expect_cal("R9 frozen during hold", t % 60, (t / 60) % 60, t / 3600, 1, 1, 1, 0);
        run_en(ENPER - 1);
        take_snap();
        expect_cal("R9 prescaler cleared", t % 60, (t / 60) % 60, t / 3600, 1, 1, 1, 0);
        run_en(1);
        take_snap();
        t = t + 1;
        expect_cal("R9 resumes after hold", t % 60, (t / 60) % 60, t / 3600, 1, 1, 1, 0);

        // R10 load with hold high, seconds forced to zero, prescaler restarted
        run_en(2);
        do_load(34, 12, 5, 17, 8, 42, 1'b1);
        take_snap();
        expect_cal("R10 load applied", 0, 34, 12, 5, 17, 8, 42);
        run_en(ENPER - 1);
        take_snap();
        expect_cal("R10 prescaler restart", 0, 34, 12, 5, 17, 8, 42);
        run_en(1);
        take_snap();
        expect_cal("R10 first tick after load", 1, 34, 12, 5, 17, 8, 42);

        // R6 R5 R8 day rollover at each month end and mid-month
        for (int mo = 1; mo <= 12; mo++) begin
            for (int yi = 0; yi < 4; yi++) begin
                int y, last, dw, ndw;
                y    = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 4 : 99;
                last = days_in(mo, y);
                dw   = (mo % 7) + 1;
                ndw  = (dw == 7) ? 1 : dw + 1;
                do_load(59, 23, dw, last, mo, y, 1'b0);
                run_en(60 * ENPER);
                take_snap();
                if (mo == 12)
                    expect_cal("R8 year end", 0, 0, 0, ndw, 1, 1, (y + 1) % 100);
                else
                    expect_cal("R6 month end", 0, 0, 0, ndw, 1, mo + 1, y);
                do_load(59, 23, dw, last - 1, mo, y, 1'b0);
                run_en(60 * ENPER);
                take_snap();
                expect_cal("R5 R6 day before month end", 0, 0, 0, ndw, last, mo, y);
            end
        end

        // R7 every February of the century
        for (int y = 0; y < 100; y++) begin
            do_load(59, 23, 7, 28, 2, y, 1'b0);
            run_en(60 * ENPER);
            take_snap();
            if (y % 4 == 0)
                expect_cal("R7 leap Feb 29", 0, 0, 0, 1, 29, 2, y);
            else
                expect_cal("R7 common Feb to Mar", 0, 0, 0, 1, 1, 3, y);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule